// File: doc/BRIEF.md
# Power-Good and Fault Supervisor

This block is the digital housekeeping core of a multi-rail switching regulator controller. It runs on the converter oscillator clock and turns two enable lines, a reference-ready flag and per-rail comparator flags into per-rail switching enables, an oscillator enable, two latched protection commands and an active-high power-good output. One enable line controls main rail A. The other controls main rail B and the auxiliary rail C together.

Power-good is asserted only after both main rails have stayed in regulation for a programmable number of oscillator cycles. The default is 32,000 cycles, about 107 ms at 300 kHz. An overvoltage on either main rail latches a crowbar command that forces every low-side driver fully on. An undervoltage on either main rail latches a shutdown command. The undervoltage check on a rail is blanked for a programmable number of cycles after that rail is enabled. The default is 6,144 cycles, about 20.48 ms at 300 kHz. Both latches stay set until each enable line has gone low and then high again. All pins are plain level control and status signals; the block has no streaming interface, so no valid/ready handshake applies.

Top module: `pwr_supervisor`

## Requirements
- R1: `rail_a_en_o` is high exactly when the synchronized enable A is high, `ref_ok_i` is high, and neither `crowbar_o` nor `shutdown_o` is set. `rail_b_en_o` and `rail_c_en_o` both follow the same rule using the synchronized enable B. All outputs are low during reset.
- R2: While `ref_ok_i` is low, `osc_en_o` and all three rail enables are low. Otherwise `osc_en_o` is high when either synchronized enable is high.
- R3: Each enable input passes through two flip-flops. A change on `en_a_i` or `en_b_i` therefore reaches the outputs on the second rising clock edge after it is applied.
- R4: `pwr_good_o` rises only after the power-good condition has held for PG_DELAY consecutive clock edges. The condition is: both rails in regulation, both synchronized enables high, and no latch set. The count starts from the moment the later rail enters regulation.
- R5: `pwr_good_o` falls in the same cycle that either rail leaves regulation, either synchronized enable goes low, or either latch is set. The delay count then restarts from zero.
- R6: The undervoltage flag of a rail is ignored until UV_BLANK clock edges have passed with that rail's synchronized enable and `ref_ok_i` both high. The blanking count restarts whenever either of them goes low.
- R7: Once a rail's undervoltage check is armed, its undervoltage flag sets `shutdown_o` at the next clock edge. This turns off all three rail enables.
- R8: An overvoltage flag on either rail sets `crowbar_o` at the next clock edge, with no blanking. This turns off all three rail enables. The crowbar stays set after the flag clears.
- R9: While a latch is set, it clears only at the edge where the second of the two synchronized enables completes a low-then-high toggle that began after the latch was set. Toggling only one enable leaves both latches set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a_i | input | 1 | Enable for rail A (asynchronous) |
| en_b_i | input | 1 | Enable for rails B and C (asynchronous) |
| ref_ok_i | input | 1 | Reference above its ready threshold |
| a_reg_i | input | 1 | Rail A in regulation |
| a_ov_i | input | 1 | Rail A overvoltage comparator |
| a_uv_i | input | 1 | Rail A undervoltage comparator |
| b_reg_i | input | 1 | Rail B in regulation |
| b_ov_i | input | 1 | Rail B overvoltage comparator |
| b_uv_i | input | 1 | Rail B undervoltage comparator |
| osc_en_o | output | 1 | Oscillator enable |
| rail_a_en_o | output | 1 | Switching allowed on rail A |
| rail_b_en_o | output | 1 | Switching allowed on rail B |
| rail_c_en_o | output | 1 | Switching allowed on auxiliary rail C |
| crowbar_o | output | 1 | Latched overvoltage command: all low-side drivers on |
| shutdown_o | output | 1 | Latched undervoltage command: all rails off and clamped |
| pwr_good_o | output | 1 | Power good, active high |

## Verification
The bench builds the block with PG_DELAY = 20 and UV_BLANK = 12 instead of 32,000 and 6,144. With these values the power-good delay, its restart after a drop, and undervoltage arming all complete within a few dozen cycles. The short values also let a single run cover the blanked and armed undervoltage cases, both latch-clear orders, and the one-sided toggle that must leave the latches set. The edge where the delay counter reaches its terminal value is sampled directly, so an off-by-one in either counter shows up at once.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // comparator view of one main rail
  typedef struct packed {
    logic in_reg;
    logic over;
    logic under;
  } rail_flags_t;

  localparam int unsigned NUM_MAIN = 2;
endpackage

// File: rtl/en_sync.sv
module en_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int unsigned CYCLES = 6144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign armed_o = (cnt == LIMIT);

  AST_ARM_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(run_i)); // R6
endmodule

// File: rtl/pg_timer.sv
module pg_timer #(
  parameter int unsigned DELAY = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_i,
  output logic pwr_good_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!good_i)      cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  // combinational drop on loss of the condition
  assign pwr_good_o = good_i && (cnt == LIMIT);

  AST_PG_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good_o |-> $past(good_i)); // R4
endmodule

// File: rtl/fault_keeper.sv
module fault_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic en_a_s_i,
  input  logic en_b_s_i,
  input  logic set_ov_i,
  input  logic set_uv_i,
  output logic crowbar_o,
  output logic shutdown_o
);
  logic en_a_q, en_b_q;
  logic off_a, off_b, back_a, back_b;
  logic rise_a, rise_b, fall_a, fall_b;
  logic ready_a, ready_b, any_fault, release_all;

  assign rise_a = en_a_s_i & ~en_a_q;
  assign rise_b = en_b_s_i & ~en_b_q;
  assign fall_a = ~en_a_s_i & en_a_q;
  assign fall_b = ~en_b_s_i & en_b_q;

  assign any_fault   = crowbar_o | shutdown_o;
  assign ready_a     = back_a | (off_a & rise_a);
  assign ready_b     = back_b | (off_b & rise_b);
  assign release_all = any_fault & ready_a & ready_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q <= 1'b0; en_b_q <= 1'b0;
      off_a  <= 1'b0; off_b  <= 1'b0;
      back_a <= 1'b0; back_b <= 1'b0;
      crowbar_o  <= 1'b0;
      shutdown_o <= 1'b0;
    end else begin
      en_a_q <= en_a_s_i;
      en_b_q <= en_b_s_i;
      if (release_all) begin
        off_a <= 1'b0; off_b <= 1'b0;
        back_a <= 1'b0; back_b <= 1'b0;
      end else begin
        if (any_fault && fall_a) off_a  <= 1'b1;
        if (any_fault && fall_b) off_b  <= 1'b1;
        if (off_a && rise_a)     back_a <= 1'b1;
        if (off_b && rise_b)     back_b <= 1'b1;
      end
      crowbar_o  <= set_ov_i | (crowbar_o  & ~release_all);
      shutdown_o <= set_uv_i | (shutdown_o & ~release_all);
    end
  end

  AST_OV_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    set_ov_i |=> crowbar_o); // R8
  AST_CLEAR_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(crowbar_o) || $fell(shutdown_o)) |-> $past(en_a_s_i && en_b_s_i)); // R9
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned PG_DELAY    = 32000,
  parameter int unsigned UV_BLANK    = 6144,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic ref_ok_i,
  input  logic a_reg_i,
  input  logic a_ov_i,
  input  logic a_uv_i,
  input  logic b_reg_i,
  input  logic b_ov_i,
  input  logic b_uv_i,
  output logic osc_en_o,
  output logic rail_a_en_o,
  output logic rail_b_en_o,
  output logic rail_c_en_o,
  output logic crowbar_o,
  output logic shutdown_o,
  output logic pwr_good_o
);
  rail_flags_t [NUM_MAIN-1:0] flags;
  logic [NUM_MAIN-1:0] en_s, armed, uv_hit;
  logic set_ov, set_uv, latched, good;

  assign flags[0] = '{in_reg: a_reg_i, over: a_ov_i, under: a_uv_i};
  assign flags[1] = '{in_reg: b_reg_i, over: b_ov_i, under: b_uv_i};

  en_sync #(.W(NUM_MAIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({en_b_i, en_a_i}), .q_o(en_s)
  );

  for (genvar r = 0; r < NUM_MAIN; r++) begin : g_rail
    blank_timer #(.CYCLES(UV_BLANK)) u_blank (
      .clk(clk), .rst_n(rst_n), .run_i(en_s[r] & ref_ok_i), .armed_o(armed[r])
    );
    assign uv_hit[r] = armed[r] & flags[r].under;
  end

  assign set_ov = flags[0].over | flags[1].over;
  assign set_uv = |uv_hit;

  fault_keeper u_fault (
    .clk(clk), .rst_n(rst_n),
    .en_a_s_i(en_s[0]), .en_b_s_i(en_s[1]),
    .set_ov_i(set_ov), .set_uv_i(set_uv),
    .crowbar_o(crowbar_o), .shutdown_o(shutdown_o)
  );

  assign latched     = crowbar_o | shutdown_o;
  assign osc_en_o    = ref_ok_i & (|en_s);
  assign rail_a_en_o = ref_ok_i & en_s[0] & ~latched;
  assign rail_b_en_o = ref_ok_i & en_s[1] & ~latched;
  assign rail_c_en_o = rail_b_en_o;

  assign good = flags[0].in_reg & flags[1].in_reg & (&en_s) & ~latched;

  pg_timer #(.DELAY(PG_DELAY)) u_pg (
    .clk(clk), .rst_n(rst_n), .good_i(good), .pwr_good_o(pwr_good_o)
  );

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_s[0]) |-> $past(en_a_i, 2)); // R3
  AST_UV_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(shutdown_o) && !$past(set_ov)) |-> $past(|armed)); // R6
  AST_PG_LOW_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (crowbar_o || shutdown_o) |-> !pwr_good_o); // R5
  AST_NO_SWITCH_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok_i |-> !(osc_en_o || rail_a_en_o || rail_b_en_o || rail_c_en_o)); // R2
endmodule

// File: tb/tb_pwr_supervisor.sv
module tb_pwr_supervisor;
  localparam int PGD = 20;
  localparam int UVB = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_a = 0, en_b = 0, ref_ok = 0;
  logic a_reg = 0, a_ov = 0, a_uv = 0, b_reg = 0, b_ov = 0, b_uv = 0;
  logic osc_en, ra, rb, rc, crow, shut, pg;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_supervisor #(.PG_DELAY(PGD), .UV_BLANK(UVB)) dut (
    .clk(clk), .rst_n(rst_n), .en_a_i(en_a), .en_b_i(en_b), .ref_ok_i(ref_ok),
    .a_reg_i(a_reg), .a_ov_i(a_ov), .a_uv_i(a_uv),
    .b_reg_i(b_reg), .b_ov_i(b_ov), .b_uv_i(b_uv),
    .osc_en_o(osc_en), .rail_a_en_o(ra), .rail_b_en_o(rb), .rail_c_en_o(rc),
    .crowbar_o(crow), .shutdown_o(shut), .pwr_good_o(pg)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_sa1, m_sa2, m_sb1, m_sb2, m_qa, m_qb;
  int m_blk_a, m_blk_b, m_pgc;
  bit m_ov, m_uv, m_offa, m_offb, m_bka, m_bkb;

  function automatic bit m_good();
    return a_reg && b_reg && m_sa2 != 0 && m_sb2 != 0 && !m_ov && !m_uv;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sa1 = 0; m_sa2 = 0; m_sb1 = 0; m_sb2 = 0; m_qa = 0; m_qb = 0;
      m_blk_a = 0; m_blk_b = 0; m_pgc = 0;
      m_ov = 0; m_uv = 0; m_offa = 0; m_offb = 0; m_bka = 0; m_bkb = 0;
    end else begin
      bit g, set_o, set_u, flt, upa, upb, dna, dnb, rdy_a, rdy_b, clr;
      g     = m_good();
      set_o = a_ov || b_ov;
      set_u = (m_blk_a == UVB && a_uv) || (m_blk_b == UVB && b_uv);
      flt   = m_ov || m_uv;
      upa = m_sa2 != 0 && m_qa == 0;  dna = m_sa2 == 0 && m_qa != 0;
      upb = m_sb2 != 0 && m_qb == 0;  dnb = m_sb2 == 0 && m_qb != 0;
      rdy_a = m_bka || (m_offa && upa);
      rdy_b = m_bkb || (m_offb && upb);
      clr = flt && rdy_a && rdy_b;
      m_pgc   = g ? ((m_pgc < PGD) ? m_pgc + 1 : PGD) : 0;
      m_blk_a = (m_sa2 != 0 && ref_ok) ? ((m_blk_a < UVB) ? m_blk_a + 1 : UVB) : 0;
      m_blk_b = (m_sb2 != 0 && ref_ok) ? ((m_blk_b < UVB) ? m_blk_b + 1 : UVB) : 0;
      if (clr) begin
        m_offa = 0; m_offb = 0; m_bka = 0; m_bkb = 0;
      end else begin
        if (flt && dna) m_offa = 1;
        if (flt && dnb) m_offb = 1;
        if (m_offa && upa) m_bka = 1;
        if (m_offb && upb) m_bkb = 1;
      end
      m_ov = set_o || (m_ov && !clr);
      m_uv = set_u || (m_uv && !clr);
      m_qa = m_sa2; m_qb = m_sb2;
      m_sa2 = m_sa1; m_sb2 = m_sb1;
      m_sa1 = en_a; m_sb1 = en_b;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit fa;
      fa = m_ov || m_uv;
      check("R1 rail A", ra, ref_ok && m_sa2 != 0 && !fa);
      check("R1 rail B", rb, ref_ok && m_sb2 != 0 && !fa);
      check("R1 rail C", rc, ref_ok && m_sb2 != 0 && !fa);
      check("R2 osc", osc_en, ref_ok && (m_sa2 != 0 || m_sb2 != 0));
      check("R8 crowbar", crow, m_ov);
      check("R7 shutdown", shut, m_uv);
      check("R4 power good", pg, m_good() && m_pgc == PGD);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    check("R1 reset rail A", ra, 1'b0);
    check("R1 reset pg", pg, 1'b0);
    check("R8 reset crowbar", crow, 1'b0);
    rst_n = 1;
    ref_ok = 1; en_a = 1; en_b = 1; a_uv = 1;   // uv during blanking
    tick(1);
    check("R3 one edge", ra, 1'b0);
    tick(1);
    check("R3 two edges A", ra, 1'b1);
    check("R3 two edges C", rc, 1'b1);
    tick(UVB - 1);
    check("R6 uv blanked", shut, 1'b0);
    a_uv = 0;
    // later rail enters regulation second
    a_reg = 1;
    tick(3);
    b_reg = 1;
    tick(PGD - 1);
    check("R4 not yet", pg, 1'b0);
    tick(1);
    check("R4 after delay", pg, 1'b1);
    b_reg = 0; #1;
    check("R5 same cycle drop", pg, 1'b0);
    tick(1);
    b_reg = 1;
    tick(PGD - 1);
    check("R5 restart low", pg, 1'b0);
    tick(1);
    check("R5 restart high", pg, 1'b1);
    // armed undervoltage on rail B
    b_uv = 1;
    tick(1);
    check("R7 shutdown set", shut, 1'b1);
    check("R7 rail C off", rc, 1'b0);
    check("R5 pg on fault", pg, 1'b0);
    b_uv = 0;
    en_a = 0; tick(5); en_a = 1; tick(6);
    check("R9 one toggle keeps", shut, 1'b1);
    en_b = 0; tick(5); en_b = 1; tick(6);
    check("R9 both toggled clears", shut, 1'b0);
    // overvoltage
    tick(4);
    a_ov = 1; tick(1); a_ov = 0;
    check("R8 crowbar set", crow, 1'b1);
    check("R8 rail A off", ra, 1'b0);
    tick(5);
    check("R8 crowbar held", crow, 1'b1);
    en_b = 0; tick(5); en_b = 1; tick(6);
    check("R9 B only keeps", crow, 1'b1);
    en_a = 0; tick(5); en_a = 1; tick(6);
    check("R9 crowbar cleared", crow, 1'b0);
    ref_ok = 0; #1;
    check("R2 no ref osc", osc_en, 1'b0);
    check("R2 no ref rail B", rb, 1'b0);
    tick(4);
    ref_ok = 1; tick(3);
    check("R2 ref back", rb, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule